// File: doc/BRIEF.md
# Shift-Register LRU Translation Buffer

This block is a small fully associative translation buffer. Each slot holds a virtual page number, a physical page number, an address-space tag, a virtual-machine tag, a secure flag, a hypervisor flag, a global flag and a two-bit access-kind tag. A combinational lookup port compares a request key against every valid slot at once. It returns a hit flag, the slot index, the physical page, the kind tag and the global flag of the matching slot.

Replacement needs no ranking logic. The slot array is a physical shift register: a fill enters slot 0 and pushes every older slot one place down, so the slot at the far end is always the least recently filled and falls off. A hit does not move a slot. When a hit comes from the other access kind, the slot's kind tag is widened to unified, so that instruction and data traffic can share one translation. A flush port drops every slot, or only the non-global slots of one address space. The virtual-machine tag used for both compare and fill comes from an internal register that a load command writes.

Top module: `tlbsr_array`

## Requirements
- R1: After reset no lookup hits, and the virtual-machine register holds zero.
- R2: A fill writes its entry into slot 0, and every valid slot moves to the next higher index in the same cycle, so a lookup of the new page right after the fill reports index 0.
- R3: With ENTRIES slots already filled, one more fill discards the entry in slot ENTRIES-1. A lookup of that page then misses, and the page filled next after it is found at index ENTRIES-1.
- R4: A lookup hits only a valid slot whose page, virtual-machine tag, secure flag, hypervisor flag and address-space tag all equal the request key. A difference in any one field gives a miss.
- R5: The address-space comparison is skipped when the lookup's ignore input is high or when the slot's global flag is set.
- R6: A load command copies its value into the virtual-machine register at the clock edge. That register is the tag compared by every later lookup and the tag stored by every later fill.
- R7: Kind tags are encoded 01 instruction, 10 data and 11 unified. A non-functional execute lookup that hits a slot whose bit 0 is clear, or a non-functional read/write lookup that hits a slot whose bit 1 is clear, sets that slot's tag to 11 at the clock edge. A hit on a slot that already covers the access kind leaves its tag unchanged.
- R8: A functional lookup reports its hit, but it never changes any slot's kind tag.
- R9: When a lookup and a fill arrive in the same cycle, both take place. The lookup result reflects the contents from before the fill.
- R10: A flush-all command invalidates every slot at the clock edge.
- R11: A flush-by-address-space command invalidates only the slots that are non-global and whose address-space tag equals the command value. Global slots and slots of other address spaces keep hitting.
- R12: When several valid slots match, the lookup reports the lowest index, which is the most recent fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vmid_load | input | 1 | Load the virtual-machine register |
| vmid_in | input | VMID_W | Value for the virtual-machine register |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_secure | input | 1 | Lookup secure flag |
| lk_hyp | input | 1 | Lookup hypervisor flag |
| lk_ignore_asid | input | 1 | Skip the address-space comparison |
| lk_exec | input | 1 | 1 for an execute access, 0 for a read/write access |
| lk_functional | input | 1 | Functional lookup that changes no state |
| lk_hit | output | 1 | A valid slot matched |
| lk_index | output | IDX_W | Index of the matching slot |
| lk_ppn | output | PPN_W | Physical page of the matching slot |
| lk_kind | output | 2 | Kind tag of the matching slot |
| lk_global | output | 1 | Global flag of the matching slot |
| ins_valid | input | 1 | Fill request |
| ins_vpn | input | VPN_W | Fill virtual page |
| ins_asid | input | ASID_W | Fill address-space tag |
| ins_secure | input | 1 | Fill secure flag |
| ins_hyp | input | 1 | Fill hypervisor flag |
| ins_global | input | 1 | Fill global flag |
| ins_ppn | input | PPN_W | Fill physical page |
| ins_kind | input | 2 | Fill kind tag |
| flush_all | input | 1 | Invalidate every slot |
| flush_asid_en | input | 1 | Invalidate the non-global slots of one address space |
| flush_asid | input | ASID_W | Address-space tag for the selective flush |

## Verification
The hardest case to reach is a promotion in the same cycle as a fill or a flush. The hit slot is widened in place and then shifted one place down, or it is dropped. That outcome is only visible on the next lookup, at a different index. Random stimulus uses a small pool of pages, address spaces and virtual-machine tags, so that hits of the other access kind, duplicate pages and fills together with lookups happen often. A bench model applies promotion, flush and shift in the same order as the requirements and predicts every lookup. Directed sequences first cover eviction of the oldest slot, each compare field, promotion in both directions, functional lookups and the two flush kinds.

// File: rtl/tlbsr_pkg.sv
package tlbsr_pkg;

   localparam logic [1:0] KIND_INSTR   = 2'b01;
   localparam logic [1:0] KIND_DATA    = 2'b10;
   localparam logic [1:0] KIND_UNIFIED = 2'b11;

   // Widen a kind tag to unified when it does not cover the access kind.
   function automatic logic [1:0] widen_kind(input logic [1:0] kind, input logic exec);
      logic covers;
      covers = exec ? kind[0] : kind[1];
      return covers ? kind : KIND_UNIFIED;
   endfunction

endpackage

// File: rtl/tlbsr_cam.sv
module tlbsr_cam #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int ASID_W  = 8,
   parameter int VMID_W  = 8
) (
   input  logic [ENTRIES-1:0] slot_valid,
   input  logic [VPN_W-1:0]   slot_vpn    [ENTRIES],
   input  logic [ASID_W-1:0]  slot_asid   [ENTRIES],
   input  logic [VMID_W-1:0]  slot_vmid   [ENTRIES],
   input  logic [ENTRIES-1:0] slot_secure,
   input  logic [ENTRIES-1:0] slot_hyp,
   input  logic [ENTRIES-1:0] slot_global,
   input  logic [VPN_W-1:0]   key_vpn,
   input  logic [ASID_W-1:0]  key_asid,
   input  logic [VMID_W-1:0]  key_vmid,
   input  logic               key_secure,
   input  logic               key_hyp,
   input  logic               key_ignore_asid,
   output logic [ENTRIES-1:0] match
);

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      logic space_ok;
      assign space_ok = slot_global[g] || key_ignore_asid || (slot_asid[g] == key_asid);
      assign match[g] = slot_valid[g]
                     && (slot_vpn[g]  == key_vpn)
                     && (slot_vmid[g] == key_vmid)
                     && (slot_secure[g] == key_secure)
                     && (slot_hyp[g]    == key_hyp)
                     && space_ok;
   end

endmodule

// File: rtl/tlbsr_prio.sv
module tlbsr_prio #(
   parameter int ENTRIES = 8,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic [ENTRIES-1:0] match,
   output logic               any,
   output logic [IDX_W-1:0]   first
);

   always_comb begin
      first = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match[i]) first = IDX_W'(i);
      end
      any = |match;
   end

endmodule

// File: rtl/tlbsr_store.sv
module tlbsr_store
   import tlbsr_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int ASID_W  = 8,
   parameter int VMID_W  = 8,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fill,
   input  logic [VPN_W-1:0]   fill_vpn,
   input  logic [ASID_W-1:0]  fill_asid,
   input  logic [VMID_W-1:0]  fill_vmid,
   input  logic               fill_secure,
   input  logic               fill_hyp,
   input  logic               fill_global,
   input  logic [PPN_W-1:0]   fill_ppn,
   input  logic [1:0]         fill_kind,
   input  logic               widen_en,
   input  logic [IDX_W-1:0]   widen_idx,
   input  logic               widen_exec,
   input  logic               drop_all,
   input  logic               drop_space_en,
   input  logic [ASID_W-1:0]  drop_space,
   output logic [ENTRIES-1:0] slot_valid,
   output logic [VPN_W-1:0]   slot_vpn    [ENTRIES],
   output logic [ASID_W-1:0]  slot_asid   [ENTRIES],
   output logic [VMID_W-1:0]  slot_vmid   [ENTRIES],
   output logic [ENTRIES-1:0] slot_secure,
   output logic [ENTRIES-1:0] slot_hyp,
   output logic [ENTRIES-1:0] slot_global,
   output logic [PPN_W-1:0]   slot_ppn    [ENTRIES],
   output logic [1:0]         slot_kind   [ENTRIES]
);

   // State after promotion and flush, before the shift.
   logic [ENTRIES-1:0] mid_valid;
   logic [1:0]         mid_kind [ENTRIES];

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         mid_valid[i] = slot_valid[i];
         mid_kind[i]  = slot_kind[i];
         if (widen_en && (widen_idx == IDX_W'(i)))
            mid_kind[i] = widen_kind(slot_kind[i], widen_exec);
         if (drop_all)
            mid_valid[i] = 1'b0;
         else if (drop_space_en && !slot_global[i] && (slot_asid[i] == drop_space))
            mid_valid[i] = 1'b0;
      end
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      if (g == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               slot_valid[0] <= 1'b0;
               slot_kind[0]  <= 2'b00;
            end else if (fill) begin
               slot_valid[0] <= 1'b1;
               slot_kind[0]  <= fill_kind;
            end else begin
               slot_valid[0] <= mid_valid[0];
               slot_kind[0]  <= mid_kind[0];
            end
         end
         always_ff @(posedge clk) begin
            if (fill) begin
               slot_vpn[0]    <= fill_vpn;
               slot_asid[0]   <= fill_asid;
               slot_vmid[0]   <= fill_vmid;
               slot_secure[0] <= fill_secure;
               slot_hyp[0]    <= fill_hyp;
               slot_global[0] <= fill_global;
               slot_ppn[0]    <= fill_ppn;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               slot_valid[g] <= 1'b0;
               slot_kind[g]  <= 2'b00;
            end else if (fill) begin
               slot_valid[g] <= mid_valid[g-1];
               slot_kind[g]  <= mid_kind[g-1];
            end else begin
               slot_valid[g] <= mid_valid[g];
               slot_kind[g]  <= mid_kind[g];
            end
         end
         always_ff @(posedge clk) begin
            if (fill) begin
               slot_vpn[g]    <= slot_vpn[g-1];
               slot_asid[g]   <= slot_asid[g-1];
               slot_vmid[g]   <= slot_vmid[g-1];
               slot_secure[g] <= slot_secure[g-1];
               slot_hyp[g]    <= slot_hyp[g-1];
               slot_global[g] <= slot_global[g-1];
               slot_ppn[g]    <= slot_ppn[g-1];
            end
         end
      end
   end

endmodule

// File: rtl/tlbsr_array.sv
module tlbsr_array #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int ASID_W  = 8,
   parameter int VMID_W  = 8,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vmid_load,
   input  logic [VMID_W-1:0] vmid_in,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_secure,
   input  logic              lk_hyp,
   input  logic              lk_ignore_asid,
   input  logic              lk_exec,
   input  logic              lk_functional,
   output logic              lk_hit,
   output logic [IDX_W-1:0]  lk_index,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic [1:0]        lk_kind,
   output logic              lk_global,
   input  logic              ins_valid,
   input  logic [VPN_W-1:0]  ins_vpn,
   input  logic [ASID_W-1:0] ins_asid,
   input  logic              ins_secure,
   input  logic              ins_hyp,
   input  logic              ins_global,
   input  logic [PPN_W-1:0]  ins_ppn,
   input  logic [1:0]        ins_kind,
   input  logic              flush_all,
   input  logic              flush_asid_en,
   input  logic [ASID_W-1:0] flush_asid
);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("tlbsr_array: ENTRIES must be at least 2");
   end
   if (VPN_W < 1 || PPN_W < 1 || ASID_W < 1 || VMID_W < 1) begin : g_bad_width
      $error("tlbsr_array: field widths must be positive");
   end

   logic [VMID_W-1:0]  vmid_q;
   logic [ENTRIES-1:0] ent_valid;
   logic [VPN_W-1:0]   ent_vpn    [ENTRIES];
   logic [ASID_W-1:0]  ent_asid   [ENTRIES];
   logic [VMID_W-1:0]  ent_vmid   [ENTRIES];
   logic [ENTRIES-1:0] ent_secure;
   logic [ENTRIES-1:0] ent_hyp;
   logic [ENTRIES-1:0] ent_global;
   logic [PPN_W-1:0]   ent_ppn    [ENTRIES];
   logic [1:0]         ent_kind   [ENTRIES];
   logic [2*ENTRIES-1:0] ent_type;
   logic [ENTRIES-1:0] match;
   logic               any_match;
   logic [IDX_W-1:0]   first_idx;
   logic               widen_en;

   always_ff @(posedge clk) begin
      if (!rst_n)         vmid_q <= '0;
      else if (vmid_load) vmid_q <= vmid_in;
   end

   tlbsr_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .VMID_W(VMID_W)) u_cam (
      .slot_valid(ent_valid), .slot_vpn(ent_vpn), .slot_asid(ent_asid), .slot_vmid(ent_vmid),
      .slot_secure(ent_secure), .slot_hyp(ent_hyp), .slot_global(ent_global),
      .key_vpn(lk_vpn), .key_asid(lk_asid), .key_vmid(vmid_q), .key_secure(lk_secure),
      .key_hyp(lk_hyp), .key_ignore_asid(lk_ignore_asid), .match(match)
   );

   tlbsr_prio #(.ENTRIES(ENTRIES)) u_prio (
      .match(match), .any(any_match), .first(first_idx)
   );

   assign lk_hit   = lk_valid && any_match;
   assign lk_index = first_idx;
   assign widen_en = lk_hit && !lk_functional;

   always_comb begin
      lk_ppn    = '0;
      lk_kind   = '0;
      lk_global = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (lk_hit && (first_idx == IDX_W'(i))) begin
            lk_ppn    = ent_ppn[i];
            lk_kind   = ent_kind[i];
            lk_global = ent_global[i];
         end
      end
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
      assign ent_type[2*g +: 2] = ent_kind[g];
   end

   tlbsr_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W), .VMID_W(VMID_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .fill(ins_valid), .fill_vpn(ins_vpn), .fill_asid(ins_asid), .fill_vmid(vmid_q),
      .fill_secure(ins_secure), .fill_hyp(ins_hyp), .fill_global(ins_global),
      .fill_ppn(ins_ppn), .fill_kind(ins_kind),
      .widen_en(widen_en), .widen_idx(first_idx), .widen_exec(lk_exec),
      .drop_all(flush_all), .drop_space_en(flush_asid_en), .drop_space(flush_asid),
      .slot_valid(ent_valid), .slot_vpn(ent_vpn), .slot_asid(ent_asid), .slot_vmid(ent_vmid),
      .slot_secure(ent_secure), .slot_hyp(ent_hyp), .slot_global(ent_global),
      .slot_ppn(ent_ppn), .slot_kind(ent_kind)
   );

endmodule

// File: rtl/tlbsr_checker.sv
module tlbsr_checker #(
   parameter int ENTRIES = 8,
   parameter int VMID_W  = 8,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 vmid_load,
   input logic [VMID_W-1:0]    vmid_in,
   input logic [VMID_W-1:0]    vmid_q,
   input logic                 lk_valid,
   input logic                 lk_functional,
   input logic                 lk_hit,
   input logic [IDX_W-1:0]     lk_index,
   input logic                 ins_valid,
   input logic                 flush_all,
   input logic                 flush_asid_en,
   input logic [ENTRIES-1:0]   ent_valid,
   input logic [2*ENTRIES-1:0] ent_type
);

   logic [IDX_W-1:0] idx_d;
   logic [1:0]       kind_at_d;
   logic             quiet;

   always_ff @(posedge clk) idx_d <= lk_index;
   assign kind_at_d = ent_type[2*int'(idx_d) +: 2];
   assign quiet     = !ins_valid && !flush_all && !flush_asid_en;

   p_no_hit_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (ent_valid != '0));

   p_fill_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ins_valid |=> ent_valid[0]);

   p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && !flush_all && !flush_asid_en)
      |=> ent_valid[ENTRIES-1:1] == $past(ent_valid[ENTRIES-2:0]));

   p_vmid_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vmid_load |=> vmid_q == $past(vmid_in));

   p_vmid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !vmid_load |=> $stable(vmid_q));

   p_widen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && !lk_functional && quiet) |=> kind_at_d != 2'b00 && (kind_at_d == 2'b11 || $stable(ent_type)));

   p_functional_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_functional && quiet) |=> $stable(ent_type));

   p_flush_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_all && !ins_valid) |=> ent_valid == '0);

endmodule

bind tlbsr_array tlbsr_checker #(.ENTRIES(ENTRIES), .VMID_W(VMID_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .vmid_load(vmid_load), .vmid_in(vmid_in), .vmid_q(vmid_q),
   .lk_valid(lk_valid), .lk_functional(lk_functional), .lk_hit(lk_hit), .lk_index(lk_index),
   .ins_valid(ins_valid), .flush_all(flush_all), .flush_asid_en(flush_asid_en),
   .ent_valid(ent_valid), .ent_type(ent_type)
);

// File: tb/tb_tlbsr_array.sv
module tb_tlbsr_array;
   localparam int N = 8, VPN_W = 20, PPN_W = 20, ASID_W = 8, VMID_W = 8;
   localparam int IDX_W = $clog2(N);

   logic clk = 1'b0, rst_n = 1'b0;
   logic vmid_load; logic [VMID_W-1:0] vmid_in;
   logic lk_valid, lk_secure, lk_hyp, lk_ignore_asid, lk_exec, lk_functional;
   logic [VPN_W-1:0] lk_vpn; logic [ASID_W-1:0] lk_asid;
   logic lk_hit, lk_global; logic [IDX_W-1:0] lk_index; logic [PPN_W-1:0] lk_ppn; logic [1:0] lk_kind;
   logic ins_valid, ins_secure, ins_hyp, ins_global;
   logic [VPN_W-1:0] ins_vpn; logic [ASID_W-1:0] ins_asid; logic [PPN_W-1:0] ins_ppn; logic [1:0] ins_kind;
   logic flush_all, flush_asid_en; logic [ASID_W-1:0] flush_asid;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   tlbsr_array #(.ENTRIES(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W), .VMID_W(VMID_W)) dut (.*);

   // Bench model of the slot array.
   bit               m_v   [N];
   logic [VPN_W-1:0] m_vpn [N];
   logic [ASID_W-1:0] m_as [N];
   logic [VMID_W-1:0] m_vm [N];
   bit               m_s [N], m_h [N], m_g [N];
   logic [PPN_W-1:0] m_ppn [N];
   logic [1:0]       m_k [N];
   logic [VMID_W-1:0] m_vreg;

   function automatic int mdl_find();
      for (int i = 0; i < N; i++)
         if (m_v[i] && m_vpn[i] == lk_vpn && m_vm[i] == m_vreg && m_s[i] == lk_secure &&
             m_h[i] == lk_hyp && (m_g[i] || lk_ignore_asid || m_as[i] == lk_asid))
            return i;
      return -1;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      vmid_load = 0; vmid_in = '0; lk_valid = 0; lk_vpn = '0; lk_asid = '0; lk_secure = 0;
      lk_hyp = 0; lk_ignore_asid = 0; lk_exec = 0; lk_functional = 0; ins_valid = 0;
      ins_vpn = '0; ins_asid = '0; ins_secure = 0; ins_hyp = 0; ins_global = 0; ins_ppn = '0;
      ins_kind = 2'b10; flush_all = 0; flush_asid_en = 0; flush_asid = '0;
   endtask

   task automatic model_update();
      int f;
      f = lk_valid ? mdl_find() : -1;
      if (f >= 0 && !lk_functional) begin
         if (!(lk_exec ? m_k[f][0] : m_k[f][1])) m_k[f] = 2'b11;
      end
      for (int i = 0; i < N; i++) begin
         if (flush_all) m_v[i] = 0;
         else if (flush_asid_en && !m_g[i] && m_as[i] == flush_asid) m_v[i] = 0;
      end
      if (ins_valid) begin
         for (int i = N - 1; i > 0; i--) begin
            m_v[i] = m_v[i-1]; m_vpn[i] = m_vpn[i-1]; m_as[i] = m_as[i-1]; m_vm[i] = m_vm[i-1];
            m_s[i] = m_s[i-1]; m_h[i] = m_h[i-1]; m_g[i] = m_g[i-1]; m_ppn[i] = m_ppn[i-1]; m_k[i] = m_k[i-1];
         end
         m_v[0] = 1; m_vpn[0] = ins_vpn; m_as[0] = ins_asid; m_vm[0] = m_vreg; m_s[0] = ins_secure;
         m_h[0] = ins_hyp; m_g[0] = ins_global; m_ppn[0] = ins_ppn; m_k[0] = ins_kind;
      end
      if (vmid_load) m_vreg = vmid_in;
   endtask

   // One cycle: compare against the model before the edge, then advance it.
   task automatic tick();
      int f;
      #1;
      if (lk_valid) begin
         f = mdl_find();
         check("R4 model hit", 32'(lk_hit), 32'(f >= 0));
         if (f >= 0) begin
            check("R12 model index", 32'(lk_index), 32'(f));
            check("R4 model ppn", 32'(lk_ppn), 32'(m_ppn[f]));
            check("R7 model kind", 32'(lk_kind), 32'(m_k[f]));
            check("R5 model global", 32'(lk_global), 32'(m_g[f]));
         end
      end
      @(posedge clk);
      model_update();
      @(negedge clk);
      idle();
   endtask

   task automatic fill(input int vpn, input int asid, input bit glb, input logic [1:0] kind);
      ins_valid = 1; ins_vpn = VPN_W'(vpn); ins_asid = ASID_W'(asid); ins_global = glb;
      ins_ppn = PPN_W'(vpn + 'h100); ins_kind = kind;
      tick();
   endtask

   // Directed lookup with explicit expectations; exp_idx < 0 skips the index, exp_kind 0 skips kind.
   task automatic probe(string tag, input int vpn, input int asid, input bit sec, input bit hyp,
                        input bit ign, input bit ex, input bit func,
                        input bit exp_hit, input int exp_idx, input logic [1:0] exp_kind);
      lk_valid = 1; lk_vpn = VPN_W'(vpn); lk_asid = ASID_W'(asid); lk_secure = sec; lk_hyp = hyp;
      lk_ignore_asid = ign; lk_exec = ex; lk_functional = func;
      #1;
      check(tag, 32'(lk_hit), 32'(exp_hit));
      if (exp_hit && exp_idx >= 0) check(tag, 32'(lk_index), 32'(exp_idx));
      if (exp_hit && exp_kind != 2'b00) check(tag, 32'(lk_kind), 32'(exp_kind));
      tick();
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(1234);
      idle();
      for (int i = 0; i < N; i++) m_v[i] = 0;
      m_vreg = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: empty after reset
      probe("R1 empty", 5, 0, 0, 0, 1, 0, 1, 0, -1, 2'b00);

      // R2 / R3: fill order and eviction
      fill('h10, 1, 0, 2'b10);
      probe("R2 head", 'h10, 1, 0, 0, 0, 0, 1, 1, 0, 2'b10);
      for (int v = 'h11; v <= 'h18; v++) fill(v, 1, 0, 2'b10);
      probe("R3 evicted", 'h10, 1, 0, 0, 0, 0, 1, 0, -1, 2'b00);
      probe("R3 tail", 'h11, 1, 0, 0, 0, 0, 1, 1, N - 1, 2'b10);
      probe("R2 newest", 'h18, 1, 0, 0, 0, 0, 1, 1, 0, 2'b10);

      // R4 / R5: compare fields
      probe("R4 asid", 'h18, 2, 0, 0, 0, 0, 1, 0, -1, 2'b00);
      probe("R4 secure", 'h18, 1, 1, 0, 0, 0, 1, 0, -1, 2'b00);
      probe("R4 hyp", 'h18, 1, 0, 1, 0, 0, 1, 0, -1, 2'b00);
      probe("R5 ignore", 'h18, 2, 0, 0, 1, 0, 1, 1, 0, 2'b10);

      // R6: virtual-machine register
      vmid_load = 1; vmid_in = 3; tick();
      probe("R6 vmid mismatch", 'h18, 1, 0, 0, 0, 0, 1, 0, -1, 2'b00);
      fill('h30, 9, 1, 2'b10);
      probe("R5 global", 'h30, 0, 0, 0, 0, 0, 1, 1, 0, 2'b10);
      vmid_load = 1; vmid_in = 0; tick();
      probe("R6 vmid other", 'h30, 9, 0, 0, 0, 0, 1, 0, -1, 2'b00);
      probe("R6 vmid back", 'h18, 1, 0, 0, 0, 0, 1, 1, 1, 2'b10);

      // R7 / R8: kind promotion
      probe("R8 func exec", 'h18, 1, 0, 0, 0, 1, 1, 1, 1, 2'b10);
      probe("R8 unchanged", 'h18, 1, 0, 0, 0, 0, 1, 1, 1, 2'b10);
      probe("R7 exec on data", 'h18, 1, 0, 0, 0, 1, 0, 1, 1, 2'b10);
      probe("R7 widened", 'h18, 1, 0, 0, 0, 0, 1, 1, 1, 2'b11);
      fill('h40, 1, 0, 2'b01);
      probe("R7 exec on instr", 'h40, 1, 0, 0, 0, 1, 0, 1, 0, 2'b01);
      probe("R7 instr kept", 'h40, 1, 0, 0, 0, 0, 1, 1, 0, 2'b01);
      probe("R7 read on instr", 'h40, 1, 0, 0, 0, 0, 0, 1, 0, 2'b01);
      probe("R7 instr widened", 'h40, 1, 0, 0, 0, 0, 1, 1, 0, 2'b11);

      // R9: lookup and fill together
      ins_valid = 1; ins_vpn = 'h50; ins_asid = 1; ins_ppn = 'h150; ins_kind = 2'b10;
      probe("R9 pre-fill miss", 'h50, 1, 0, 0, 0, 0, 1, 0, -1, 2'b00);
      probe("R9 after fill", 'h50, 1, 0, 0, 0, 0, 1, 1, 0, 2'b10);

      // R12: duplicates resolve to the newest
      fill('h60, 1, 0, 2'b10);
      ins_valid = 1; ins_vpn = 'h60; ins_asid = 1; ins_ppn = 'h777; ins_kind = 2'b01; tick();
      lk_valid = 1; lk_vpn = 'h60; lk_asid = 1; lk_functional = 1; #1;
      check("R12 newest ppn", 32'(lk_ppn), 32'h777);
      check("R12 newest index", 32'(lk_index), 0);
      tick();

      // R11: selective flush
      fill('h70, 2, 0, 2'b10);
      fill('h71, 1, 1, 2'b10);
      flush_asid_en = 1; flush_asid = 1; tick();
      probe("R11 dropped", 'h18, 1, 0, 0, 0, 0, 1, 0, -1, 2'b00);
      probe("R11 other space", 'h70, 2, 0, 0, 0, 0, 1, 1, 1, 2'b10);
      probe("R11 global kept", 'h71, 1, 0, 0, 0, 0, 1, 1, 0, 2'b10);

      // R10: flush all
      flush_all = 1; tick();
      probe("R10 flushed", 'h70, 2, 0, 0, 0, 0, 1, 0, -1, 2'b00);
      probe("R10 flushed g", 'h71, 1, 0, 0, 1, 0, 1, 0, -1, 2'b00);

      // Random traffic against the model
      for (int c = 0; c < 4000; c++) begin
         lk_valid = ($urandom_range(0, 3) != 0);
         lk_vpn = VPN_W'($urandom_range(0, 7)); lk_asid = ASID_W'($urandom_range(0, 3));
         lk_secure = ($urandom_range(0, 7) == 0); lk_hyp = ($urandom_range(0, 7) == 0);
         lk_ignore_asid = ($urandom_range(0, 5) == 0); lk_exec = $urandom_range(0, 1);
         lk_functional = ($urandom_range(0, 3) == 0);
         ins_valid = ($urandom_range(0, 2) == 0);
         ins_vpn = VPN_W'($urandom_range(0, 7)); ins_asid = ASID_W'($urandom_range(0, 3));
         ins_secure = ($urandom_range(0, 7) == 0); ins_hyp = ($urandom_range(0, 7) == 0);
         ins_global = ($urandom_range(0, 5) == 0); ins_ppn = PPN_W'($urandom);
         ins_kind = 2'($urandom_range(1, 3));
         flush_all = ($urandom_range(0, 120) == 0);
         flush_asid_en = ($urandom_range(0, 40) == 0); flush_asid = ASID_W'($urandom_range(0, 3));
         vmid_load = ($urandom_range(0, 60) == 0); vmid_in = VMID_W'($urandom_range(0, 1));
         tick();
      end

      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule